// File: doc/BRIEF.md
# Coefficient Bank Loader

This block fills the coefficient store of a multirate FIR filter. The store is six banks. Each bank has 108 entries of 24 bits, and each entry holds the coefficients of two neighbouring taps. The loader is driven from an 8-bit data bus, a 10-bit address, an active-low write strobe, an active-low select and a configure strobe. The falling edge of the configure strobe latches a 7-bit configuration word, and that word picks one of three ways of loading.

The two random-access modes build each 24-bit entry from three byte writes. The first two bytes go into address-mapped staging registers and the third goes to a bank. One of these modes is synchronous to the clock. The other takes asynchronous strobes and synchronises them to the clock. The serial mode shifts in one bit per write-strobe edge and walks through every entry of every bank. When the last entry is written it raises a completion flag and returns to run mode by itself.

A read port returns the six bank words at one location, as the filter datapath would see them. The block reports at all times whether the filter is in load mode or run mode.

Top module: `coef_loader`

## Requirements
- R1: After reset the configuration word is zero, which selects serial mode. The completion flag is low and the load-mode output is high.
- R2: On the falling edge of `cfg_strobe`, after a two-flop synchroniser, `data_in[6:0]` is latched into `cfg_word`. Bits 6..5 select the mode: 00 serial, 01 parallel, 10 microprocessor, 11 reserved.
- R3: `addr_in[9:7]` selects the target of a byte write. 110 writes staging register A, which holds word bits 7..0. 111 writes staging register B, which holds bits 15..8. 000 to 101 write bank 0 to 5 at location `addr_in[6:0]` with the word {data byte, B, A}. Bank b appears on `coef_words[24b+23:24b]`. Bits 23..12 of an entry belong to the lower-numbered tap of its pair.
- R4: In parallel mode, one byte is written on every rising clock edge during which both `wr_n` and `sel_n` are low, and writes may run back to back. `load_mode` is high exactly while both are low. When `sel_n` is high, nothing is written.
- R5: In microprocessor mode, `load_mode` follows the synchronised inverse of `sel_n`. A byte is written once per synchronised falling edge of `wr_n`, and only while the synchronised `sel_n` is low.
- R6: In serial mode, `data_in[7]` is shifted in, MSB first, on each synchronised falling edge of `wr_n` while `sel_n` is low. Every 24 bits form one entry. Entries are filled location 0 to 107 within a bank, and bank 0 first through bank 5.
- R7: After the 15552nd serial bit, `serial_done` goes high and `load_mode` goes low. Further serial bits change no memory contents.
- R8: Byte writes to a bank location of 108 or more are dropped. The read port returns zero for such locations.
- R9: While the synchronised configure strobe is high, `load_mode` is low, and the serial counters, the completion flag and both staging registers are cleared. Bank contents are kept.
- R10: In reserved mode, no write occurs and `load_mode` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_strobe | input | 1 | Configure strobe; high clears control, falling edge latches config |
| data_in | input | 8 | Byte data, serial bit on bit 7, config on bits 6..0 |
| addr_in | input | 10 | Target select (9..7) and location (6..0) |
| wr_n | input | 1 | Active-low write strobe |
| sel_n | input | 1 | Active-low select |
| rd_loc | input | 7 | Location read on all banks |
| cfg_word | output | 7 | Latched configuration word |
| load_mode | output | 1 | High in load mode, low in run mode |
| serial_done | output | 1 | Serial load complete |
| coef_words | output | 144 | Six bank words at `rd_loc`, bank 0 in the low bits |

## Verification
Parallel loading is tried with six table entries. Their bytes differ in every lane, so swapping the staging registers or shifting a byte position shows up at once. Two of the entries share a location in different banks, which exposes any bank decode that aliases. Location 107 is written and location 110 is rejected; together they separate a correct range check from a wrap-around modulo 108. Each serial word carries its own bank and location in its upper bits, so any ordering or bit-order mistake lands a recognisable wrong value in the entries read back. Strobes with the select high, writes in the reserved mode and a bank write right after reconfiguration show that gating and the staging clear are applied.

// File: rtl/cl_pkg.sv
// Shared constants and types for the coefficient bank loader.
// Assumes the fixed address map: three target bits above seven location bits.
package cl_pkg;
    localparam int NUM_BANKS = 6;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 3 * BYTE_W;
    localparam int LOC_W     = 7;
    localparam int DEST_W    = 3;
    localparam int ADDR_W    = DEST_W + LOC_W;
    localparam int CFG_W     = 7;
    localparam int BANK_W    = $clog2(NUM_BANKS);

    localparam logic [DEST_W-1:0] DEST_STAGE_A = 3'b110;
    localparam logic [DEST_W-1:0] DEST_STAGE_B = 3'b111;

    typedef enum logic [1:0] {
        MODE_SERIAL   = 2'b00,
        MODE_PARALLEL = 2'b01,
        MODE_MICRO    = 2'b10,
        MODE_RSVD     = 2'b11
    } load_mode_e;
endpackage

// File: rtl/cl_sync.sv
// Two-flop synchroniser for a vector of asynchronous strobes.
// Assumes each bit is independent; RST_VAL gives the idle level per bit.
module cl_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Purpose: two register stages toward the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/cl_bank_mem.sv
// One coefficient bank: DEPTH words, synchronous write, combinational read.
// Assumes the writer only presents locations below DEPTH; reads above return zero.
module cl_bank_mem #(
    parameter int DEPTH  = 108,
    parameter int WORD_W = 24,
    parameter int LOC_W  = 7
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LOC_W-1:0]  wloc,
    input  logic [WORD_W-1:0] wdata,
    input  logic [LOC_W-1:0]  rloc,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Purpose: store a word; contents are not reset.
    always_ff @(posedge clk) begin
        if (we) mem[wloc] <= wdata;
    end

    // Purpose: read with range guard.
    always_comb begin
        rdata = (32'(rloc) < DEPTH) ? mem[rloc] : '0;
    end
endmodule

// File: rtl/cl_serial_seq.sv
// Bit-serial sequencer: gathers 24 bits MSB first per entry, walks locations
// inside banks, and flags completion after the last entry of the last bank.
// Assumes stb is a single-cycle pulse per bit.
module cl_serial_seq
    import cl_pkg::*;
#(
    parameter int DEPTH = 108
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              stb,
    input  logic              bit_in,
    output logic              we,
    output logic [BANK_W-1:0] wbank,
    output logic [LOC_W-1:0]  wloc,
    output logic [WORD_W-1:0] word,
    output logic              done
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0]  LAST_BIT  = CNT_W'(WORD_W - 1);
    localparam logic [LOC_W-1:0]  LAST_LOC  = LOC_W'(DEPTH - 1);
    localparam logic [BANK_W-1:0] LAST_BANK = BANK_W'(NUM_BANKS - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [LOC_W-1:0]  loc;
    logic [BANK_W-1:0] bank;
    logic [WORD_W-1:0] shreg;

    // Purpose: shift bits, emit a write per full word, advance position.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            bit_cnt <= '0;
            loc     <= '0;
            bank    <= '0;
            shreg   <= '0;
            we      <= 1'b0;
            wbank   <= '0;
            wloc    <= '0;
            word    <= '0;
            done    <= 1'b0;
        end else begin
            we <= 1'b0;
            if (en && stb && !done) begin
                shreg <= {shreg[WORD_W-2:0], bit_in};
                if (bit_cnt == LAST_BIT) begin
                    bit_cnt <= '0;
                    we      <= 1'b1;
                    word    <= {shreg[WORD_W-2:0], bit_in};
                    wbank   <= bank;
                    wloc    <= loc;
                    if (loc == LAST_LOC) begin
                        loc <= '0;
                        if (bank == LAST_BANK) done <= 1'b1;
                        else                   bank <= bank + 1'b1;
                    end else begin
                        loc <= loc + 1'b1;
                    end
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/coef_loader.sv
// Coefficient bank loader top: configuration latch, strobe synchronisers,
// byte staging for random-access modes, serial sequencer, six banks.
// Assumes data_in and addr_in are held stable while an asynchronous strobe
// is being synchronised; parallel-mode inputs are synchronous to clk.
module coef_loader
    import cl_pkg::*;
#(
    parameter int DEPTH = 108
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_strobe,
    input  logic [BYTE_W-1:0]           data_in,
    input  logic [ADDR_W-1:0]           addr_in,
    input  logic                        wr_n,
    input  logic                        sel_n,
    input  logic [LOC_W-1:0]            rd_loc,
    output logic [CFG_W-1:0]            cfg_word,
    output logic                        load_mode,
    output logic                        serial_done,
    output logic [NUM_BANKS*WORD_W-1:0] coef_words
);
    logic [2:0] sync_q;
    logic       cfg_q, wr_q, sel_q;
    logic       cfg_prev, wr_prev;
    logic       cfg_fell, wr_fell;
    load_mode_e mode;

    logic [BYTE_W-1:0] stage_a, stage_b;
    logic [DEST_W-1:0] dest;
    logic [LOC_W-1:0]  aloc;
    logic              rand_stb, rand_we;

    logic              ser_we;
    logic [BANK_W-1:0] ser_bank;
    logic [LOC_W-1:0]  ser_loc;
    logic [WORD_W-1:0] ser_word;

    logic [DEST_W-1:0]    w_bank;
    logic [LOC_W-1:0]     w_loc;
    logic [WORD_W-1:0]    w_word;
    logic [NUM_BANKS-1:0] bank_we;

    cl_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({sel_n, wr_n, cfg_strobe}),
        .q(sync_q)
    );
    assign cfg_q = sync_q[0];
    assign wr_q  = sync_q[1];
    assign sel_q = sync_q[2];

    // Purpose: previous synchronised levels for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_prev <= 1'b0;
            wr_prev  <= 1'b1;
        end else begin
            cfg_prev <= cfg_q;
            wr_prev  <= wr_q;
        end
    end
    assign cfg_fell = cfg_prev & ~cfg_q;
    assign wr_fell  = wr_prev & ~wr_q;

    // Purpose: latch configuration word on configure falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_word <= '0;
        else if (cfg_fell) cfg_word <= data_in[CFG_W-1:0];
    end
    assign mode = load_mode_e'(cfg_word[6:5]);

    assign dest = addr_in[ADDR_W-1:LOC_W];
    assign aloc = addr_in[LOC_W-1:0];

    // Purpose: qualify a random-access byte write by mode and strobes.
    always_comb begin
        rand_stb = 1'b0;
        if (!cfg_q) begin
            case (mode)
                MODE_PARALLEL: rand_stb = !wr_n && !sel_n;
                MODE_MICRO:    rand_stb = wr_fell && !sel_q;
                default:       rand_stb = 1'b0;
            endcase
        end
        rand_we = rand_stb && (32'(dest) < NUM_BANKS) && (32'(aloc) < DEPTH);
    end

    // Purpose: hold the low and middle bytes until the bank write.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_q) begin
            stage_a <= '0;
            stage_b <= '0;
        end else if (rand_stb) begin
            if (dest == DEST_STAGE_A) stage_a <= data_in;
            if (dest == DEST_STAGE_B) stage_b <= data_in;
        end
    end

    cl_serial_seq #(.DEPTH(DEPTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .clr(cfg_q),
        .en(mode == MODE_SERIAL), .stb(wr_fell && !sel_q),
        .bit_in(data_in[BYTE_W-1]),
        .we(ser_we), .wbank(ser_bank), .wloc(ser_loc), .word(ser_word),
        .done(serial_done)
    );

    // Purpose: merge the two write sources (exclusive by mode).
    always_comb begin
        if (ser_we) begin
            w_bank = DEST_W'(ser_bank);
            w_loc  = ser_loc;
            w_word = ser_word;
        end else begin
            w_bank = dest;
            w_loc  = aloc;
            w_word = {data_in, stage_b, stage_a};
        end
    end

    generate
        for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
            assign bank_we[g] = (ser_we || rand_we) && (w_bank == DEST_W'(g));
            cl_bank_mem #(.DEPTH(DEPTH), .WORD_W(WORD_W), .LOC_W(LOC_W)) u_mem (
                .clk(clk), .we(bank_we[g]), .wloc(w_loc), .wdata(w_word),
                .rloc(rd_loc), .rdata(coef_words[g*WORD_W +: WORD_W])
            );
        end
    endgenerate

    // Purpose: report load versus run mode.
    always_comb begin
        if (cfg_q) load_mode = 1'b0;
        else begin
            case (mode)
                MODE_SERIAL:   load_mode = !serial_done;
                MODE_PARALLEL: load_mode = !wr_n && !sel_n;
                MODE_MICRO:    load_mode = !sel_q;
                default:       load_mode = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/cl_checker.sv
// Property checker for coef_loader, attached by bind.
module cl_checker
    import cl_pkg::*;
#(
    parameter int DEPTH = 108
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_q,
    input load_mode_e           mode,
    input logic [NUM_BANKS-1:0] bank_we,
    input logic [LOC_W-1:0]     w_loc,
    input logic                 serial_done,
    input logic                 load_mode
);
    assert_bank_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    assert_loc_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_we) |-> (32'(w_loc) < DEPTH));

    assert_par_write_in_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PARALLEL && |bank_we) |-> load_mode);

    assert_micro_write_in_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MICRO && |bank_we) |-> load_mode);

    assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_done && !cfg_q) |=> serial_done);

    assert_done_on_last_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(serial_done) |-> bank_we[NUM_BANKS-1]);

    assert_cfg_clears_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q |=> !serial_done);

    assert_reserved_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RSVD) |-> (!load_mode && !(|bank_we)));
endmodule

bind coef_loader cl_checker #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_q(cfg_q), .mode(mode),
    .bank_we(bank_we), .w_loc(w_loc), .serial_done(serial_done),
    .load_mode(load_mode)
);

// File: tb/tb_coef_loader.sv
module tb_coef_loader;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 6;
    localparam int DEPTH = 108;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_strobe = 1'b0;
    logic [7:0]   data_in = '0;
    logic [9:0]   addr_in = '0;
    logic         wr_n = 1'b1;
    logic         sel_n = 1'b1;
    logic [6:0]   rd_loc = '0;
    logic [6:0]   cfg_word;
    logic         load_mode;
    logic         serial_done;
    logic [143:0] coef_words;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coef_loader dut (
        .clk(clk), .rst_n(rst_n), .cfg_strobe(cfg_strobe), .data_in(data_in),
        .addr_in(addr_in), .wr_n(wr_n), .sel_n(sel_n), .rd_loc(rd_loc),
        .cfg_word(cfg_word), .load_mode(load_mode), .serial_done(serial_done),
        .coef_words(coef_words)
    );

    // {bank[2:0], loc[6:0], word[23:0]}
    localparam logic [33:0] VEC [6] = '{
        {3'd0, 7'd0,   24'hFB2EF4},
        {3'd5, 7'd107, 24'hCCCDDD},
        {3'd2, 7'd2,   24'h123456},
        {3'd3, 7'd50,  24'hA5A5A5},
        {3'd1, 7'd2,   24'h0F0F0F},
        {3'd4, 7'd99,  24'h800001}
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic rd(input int b, input int l, output logic [23:0] w);
        rd_loc = 7'(l);
        #1;
        w = coef_words[b*24 +: 24];
    endtask

    task automatic configure(input logic [6:0] c);
        data_in = {1'b0, c};
        cfg_strobe = 1'b1;
        repeat (3) @(negedge clk);
        cfg_strobe = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic par_write(input logic [2:0] d, input logic [6:0] l, input logic [7:0] v);
        addr_in = {d, l};
        data_in = v;
        wr_n = 1'b0;
        sel_n = 1'b0;
        @(negedge clk);
    endtask

    task automatic micro_write(input logic s, input logic [2:0] d, input logic [6:0] l,
                               input logic [7:0] v);
        addr_in = {d, l};
        data_in = v;
        sel_n = s;
        wr_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic ser_bit(input logic b);
        data_in = {b, 7'd0};
        sel_n = 1'b0;
        wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [23:0] sword(input int b, input int l);
        return {4'(b), 1'b1, 7'(l), 12'((b * 300 + l * 7 + 5) % 4096)};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [23:0] w;
        logic [23:0] sw;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 cfg_word", 32'(cfg_word), 32'h0);
        chk("R1 serial_done", 32'(serial_done), 32'h0);
        chk("R1 load_mode", 32'(load_mode), 32'h1);

        // R2: configure into parallel mode with extra bits
        configure(7'h35);
        chk("R2 cfg_word latch", 32'(cfg_word), 32'h35);
        chk("R4 load_mode idle", 32'(load_mode), 32'h0);

        // R3/R4: table of vectors, back-to-back parallel writes
        for (int i = 0; i < 6; i++) begin
            par_write(3'b110, 7'd0, VEC[i][7:0]);
            if (i == 0) chk("R4 load_mode during write", 32'(load_mode), 32'h1);
            par_write(3'b111, 7'd0, VEC[i][15:8]);
            par_write(VEC[i][33:31], VEC[i][30:24], VEC[i][23:16]);
        end
        wr_n = 1'b1; sel_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            rd(int'(VEC[i][33:31]), int'(VEC[i][30:24]), w);
            chk("R3 parallel word", 32'(w), 32'(VEC[i][23:0]));
        end
        rd(0, 0, w);
        chk("R3 lower tap of pair", 32'(w[23:12]), 32'hFB2);
        chk("R3 higher tap of pair", 32'(w[11:0]), 32'hEF4);

        // R8: out-of-range location dropped, no wrap onto location 2
        par_write(3'b001, 7'd110, 8'h77);
        wr_n = 1'b1; sel_n = 1'b1;
        @(negedge clk);
        rd(1, 110, w);
        chk("R8 read beyond depth", 32'(w), 32'h0);
        rd(1, 2, w);
        chk("R8 no alias", 32'(w), 32'h0F0F0F);

        // R4: strobe with select high writes nothing
        addr_in = {3'b011, 7'd50}; data_in = 8'h00; wr_n = 1'b0; sel_n = 1'b1;
        @(negedge clk);
        chk("R4 no load when sel high", 32'(load_mode), 32'h0);
        wr_n = 1'b1;
        @(negedge clk);
        rd(3, 50, w);
        chk("R4 sel high ignored", 32'(w), 32'hA5A5A5);

        // R5: microprocessor mode
        configure(7'h43);
        chk("R2 micro cfg", 32'(cfg_word), 32'h43);
        sel_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R5 load_mode sel low", 32'(load_mode), 32'h1);
        micro_write(1'b0, 3'b110, 7'd0, 8'h11);
        micro_write(1'b0, 3'b111, 7'd0, 8'h22);
        micro_write(1'b0, 3'b001, 7'd10, 8'h33);
        rd(1, 10, w);
        chk("R5 micro word", 32'(w), 32'h332211);
        sel_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R5 load_mode sel high", 32'(load_mode), 32'h0);
        micro_write(1'b1, 3'b001, 7'd10, 8'h99);
        rd(1, 10, w);
        chk("R5 write with sel high ignored", 32'(w), 32'h332211);

        // R9: configure clears staging, keeps banks
        data_in = 8'h20; cfg_strobe = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 load_mode low during configure", 32'(load_mode), 32'h0);
        cfg_strobe = 1'b0;
        repeat (4) @(negedge clk);
        par_write(3'b010, 7'd7, 8'h5C);
        wr_n = 1'b1; sel_n = 1'b1;
        @(negedge clk);
        rd(2, 7, w);
        chk("R9 staging cleared", 32'(w), 32'h5C0000);
        rd(3, 50, w);
        chk("R9 bank kept", 32'(w), 32'hA5A5A5);

        // R10: reserved mode
        configure(7'h60);
        addr_in = {3'b010, 7'd7}; data_in = 8'hEE; wr_n = 1'b0; sel_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 load_mode low", 32'(load_mode), 32'h0);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        sel_n = 1'b1;
        rd(2, 7, w);
        chk("R10 no write", 32'(w), 32'h5C0000);

        // R6/R7: full serial load
        configure(7'h00);
        chk("R7 not done at start", 32'(serial_done), 32'h0);
        chk("R6 load_mode serial", 32'(load_mode), 32'h1);
        for (int b = 0; b < NB; b++) begin
            for (int l = 0; l < DEPTH; l++) begin
                sw = sword(b, l);
                for (int i = 23; i >= 0; i--) begin
                    if (b == NB-1 && l == DEPTH-1 && i == 0)
                        chk("R7 done low before last bit", 32'(serial_done), 32'h0);
                    ser_bit(sw[i]);
                end
            end
        end
        sel_n = 1'b1;
        @(negedge clk);
        chk("R7 done high", 32'(serial_done), 32'h1);
        chk("R7 run mode", 32'(load_mode), 32'h0);
        rd(0, 0, w);
        chk("R6 first entry", 32'(w), 32'(sword(0, 0)));
        rd(2, 50, w);
        chk("R6 middle entry", 32'(w), 32'(sword(2, 50)));
        rd(5, 107, w);
        chk("R6 last entry", 32'(w), 32'(sword(5, 107)));
        for (int i = 0; i < 24; i++) ser_bit(1'b1);
        sel_n = 1'b1;
        @(negedge clk);
        rd(0, 0, w);
        chk("R7 extra bits ignored", 32'(w), 32'(sword(0, 0)));
        chk("R7 done stays", 32'(serial_done), 32'h1);

        // R9: reconfigure clears the flag, keeps memory
        configure(7'h00);
        chk("R9 done cleared", 32'(serial_done), 32'h0);
        rd(5, 107, w);
        chk("R9 serial data kept", 32'(w), 32'(sword(5, 107)));

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule